// File: doc/BRIEF.md
# Three-wire serial memory slave

This block models the slave side of a three-wire serial EEPROM. The host drives a chip select, a serial clock and a serial data line. All three are oversampled on the fabric clock. A start bit frames each instruction. It is followed by a two-bit opcode, an address and, for the two writing commands, a data word. A single data-out pin carries two kinds of output. During a read it returns memory contents. After a programming command has been launched it shows a ready/busy level.

The width input picks one of two views of the same storage. In the first, the storage is 1024 words of 16 bits with a 10-bit address. In the second, it is 2048 bytes with an 11-bit address. A separate programming engine performs erase and write after a fixed settling delay. It walks the whole array for the bulk commands. The front end starts it with a one-cycle launch pulse and watches its busy flag. The data-out value comes with an output-enable, so the surrounding pad logic can tri-state the line.

Top module: `mw_serial_mem`

## Requirements
- R1: While chip select is high, serial clock rising edges with data-in low do nothing, and data-out stays released (`so_en` = 0). The first rising edge with data-in high is taken as the start bit.
- R2: The two bits after the start select the command: 10 read, 01 write, 11 erase. Code 00 is an extended command selected by the two most significant address bits: 11 enable, 00 disable, 10 erase all, 01 write all. The other address bits of an extended command are ignored.
- R3: With `org16` = 1 the address is 10 bits and a data word is 16 bits. With `org16` = 0 the address is 11 bits and a data word is 8 bits. Byte address 2k holds bits 15:8 and byte address 2k+1 holds bits 7:0 of word k.
- R4: After the last address bit of a read, data-out is enabled and shows a single 0. Each following serial rising edge presents the next data bit, most significant first.
- R5: While chip select stays high, a read continues with the next address after each complete word. The highest address is followed by address 0.
- R6: After reset, programming is disabled. Erase, write, erase-all and write-all leave the storage unchanged and show no status until an enable command has run. A disable command blocks them again.
- R7: An instruction whose last bit never arrives before chip select falls is not executed.
- R8: Data-out is released within two fabric clocks of chip select going low, and the command decoder returns to waiting for a start bit.
- R9: After a launched erase or write, data-out is enabled. It reads 0 while the engine is busy and 1 once it is done. This status display ends at the next start bit.
- R10: Erase sets the addressed word or byte to all ones. Erase-all sets every location to all ones.
- R11: Write stores the received data at the addressed word or byte. Write-all stores it in every location; in 8-bit mode the byte is put in both halves of each word.
- R12: A command that changes storage takes effect only when all of its opcode, address and data bits have been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the host, active high |
| sclk | input | 1 | Serial clock from the host, oversampled |
| di | input | 1 | Serial data from the host |
| org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| so | output | 1 | Serial data-out value |
| so_en | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
A serial rising edge is registered once in the input stage. It changes the decoder state on the next fabric clock, and data-out shows the result one clock after that. The bench holds each serial clock phase for four fabric clocks and samples `so`/`so_en` at the end of the low phase. By then every effect of the preceding rising edge has settled. Release after chip select falls is due within two clocks, so a per-clock monitor checks it from the third low clock onward. Busy status is checked on the sample right after the last command bit. Ready is checked only after a wait longer than the settling delay plus a full array walk.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  localparam logic [1:0] SUB_LOCK  = 2'b00;
  localparam logic [1:0] SUB_FILL  = 2'b01;
  localparam logic [1:0] SUB_WIPE  = 2'b10;
  localparam logic [1:0] SUB_ARM   = 2'b11;

  typedef enum logic [1:0] {FE_IDLE, FE_SHIFT, FE_READ, FE_STAT} fe_state_e;
  typedef enum logic [1:0] {PK_ERASE1, PK_WRITE1, PK_ERASEALL, PK_WRITEALL} prog_kind_e;
  typedef enum logic [1:0] {EN_IDLE, EN_WAIT, EN_APPLY} eng_state_e;
endpackage

// File: rtl/mw_store.sv
`timescale 1ns/1ps
module mw_store #(
  parameter int WORD_AW = 10,
  parameter int HALF    = 8
) (
  input  logic                 clk,
  input  logic [1:0]           we,
  input  logic [WORD_AW-1:0]   w_addr,
  input  logic [HALF-1:0]      w_hi,
  input  logic [HALF-1:0]      w_lo,
  input  logic [WORD_AW-1:0]   r_addr,
  output logic [2*HALF-1:0]    r_word
);
  localparam int DEPTH = 1 << WORD_AW;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [HALF-1:0] mem [DEPTH];
    logic [HALF-1:0] q;
    logic [HALF-1:0] wd;
    assign wd = (g == 1) ? w_hi : w_lo;
    always_ff @(posedge clk) begin
      if (we[g]) mem[w_addr] <= wd;
      q <= mem[r_addr];
    end
    assign r_word[g*HALF +: HALF] = q;
  end
endmodule

// File: rtl/mw_prog_engine.sv
`timescale 1ns/1ps
module mw_prog_engine import mw_pkg::*; #(
  parameter int WORD_AW     = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  prog_kind_e           kind,
  input  logic [WORD_AW:0]     p_addr,
  input  logic [DATA_W-1:0]    p_data,
  input  logic                 org16,
  output logic                 busy,
  output logic [1:0]           we,
  output logic [WORD_AW-1:0]   w_addr,
  output logic [DATA_W/2-1:0]  w_hi,
  output logic [DATA_W/2-1:0]  w_lo
);
  localparam int HALF = DATA_W / 2;
  localparam int TW   = $clog2(PROG_CYCLES + 1);

  eng_state_e          est;
  logic [TW-1:0]       tcnt;
  logic [WORD_AW-1:0]  walk;
  prog_kind_e          k_r;
  logic [WORD_AW:0]    a_r;
  logic [DATA_W-1:0]   d_r;
  logic                o_r;
  logic                all_k, erase_k;

  assign all_k   = (k_r == PK_ERASEALL) || (k_r == PK_WRITEALL);
  assign erase_k = (k_r == PK_ERASE1)   || (k_r == PK_ERASEALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      est  <= EN_IDLE;
      tcnt <= '0;
      walk <= '0;
      k_r  <= PK_ERASE1;
      a_r  <= '0;
      d_r  <= '0;
      o_r  <= 1'b1;
    end else begin
      case (est)
        EN_IDLE: if (go) begin
          k_r  <= kind;
          a_r  <= p_addr;
          d_r  <= p_data;
          o_r  <= org16;
          tcnt <= '0;
          est  <= EN_WAIT;
        end
        EN_WAIT: begin
          if (tcnt == TW'(PROG_CYCLES - 1)) begin
            est  <= EN_APPLY;
            walk <= all_k ? '0 : (o_r ? a_r[WORD_AW-1:0] : a_r[WORD_AW:1]);
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        EN_APPLY: begin
          if (!all_k || (walk == {WORD_AW{1'b1}})) est <= EN_IDLE;
          else walk <= walk + 1'b1;
        end
        default: est <= EN_IDLE;
      endcase
    end
  end

  always_comb begin
    busy   = (est != EN_IDLE);
    w_addr = walk;
    w_lo   = erase_k ? '1 : d_r[HALF-1:0];
    w_hi   = erase_k ? '1 : (o_r ? d_r[DATA_W-1:HALF] : d_r[HALF-1:0]);
    if (est != EN_APPLY)   we = 2'b00;
    else if (all_k || o_r) we = 2'b11;
    else                   we = a_r[0] ? 2'b01 : 2'b10;
  end
endmodule

// File: rtl/mw_frontend.sv
`timescale 1ns/1ps
module mw_frontend import mw_pkg::*; #(
  parameter int WORD_AW = 10,
  parameter int DATA_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs,
  input  logic                 sclk,
  input  logic                 di,
  input  logic                 org16,
  input  logic                 eng_busy,
  input  logic [DATA_W-1:0]    rd_word,
  output logic [WORD_AW-1:0]   rd_addr,
  output logic                 go,
  output prog_kind_e           kind,
  output logic [WORD_AW:0]     p_addr,
  output logic [DATA_W-1:0]    p_data,
  output logic                 wren,
  output logic                 stat,
  output logic                 so,
  output logic                 so_en
);
  localparam int BYTE_AW = WORD_AW + 1;
  localparam int HALF    = DATA_W / 2;
  localparam int KW      = (2 + BYTE_AW > DATA_W) ? 2 + BYTE_AW : DATA_W;
  localparam int CW      = $clog2(2 + BYTE_AW + DATA_W + 1);
  localparam int IW      = $clog2(DATA_W);

  logic s_cs, s_clk, s_clk_d, s_di, rise;
  fe_state_e           st;
  logic [KW-2:0]       shreg;
  logic [KW-1:0]       sh_next;
  logic [CW-1:0]       cnt, cnt_next, n_addr, n_data;
  logic [1:0]          op_w, sub_w, op_r;
  logic [BYTE_AW-1:0]  addr_w, addr_r, ptr, ptr_inc;
  logic [DATA_W-1:0]   data_w;
  logic [IW-1:0]       ridx, last_idx, hi_idx, lo_idx;
  logic                rdbit, rd_bit, needs_data_w, can_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cs <= 1'b0; s_clk <= 1'b0; s_clk_d <= 1'b0; s_di <= 1'b0;
    end else begin
      s_cs <= cs; s_clk <= sclk; s_clk_d <= s_clk; s_di <= di;
    end
  end
  assign rise = s_clk & ~s_clk_d;

  always_comb begin
    sh_next      = {shreg, s_di};
    cnt_next     = cnt + 1'b1;
    n_addr       = org16 ? CW'(2 + WORD_AW) : CW'(2 + BYTE_AW);
    n_data       = org16 ? CW'(2 + WORD_AW + DATA_W) : CW'(2 + BYTE_AW + HALF);
    op_w         = org16 ? sh_next[WORD_AW+1:WORD_AW] : sh_next[BYTE_AW+1:BYTE_AW];
    sub_w        = org16 ? sh_next[WORD_AW-1:WORD_AW-2] : sh_next[BYTE_AW-1:BYTE_AW-2];
    addr_w       = org16 ? {1'b0, sh_next[WORD_AW-1:0]} : sh_next[BYTE_AW-1:0];
    data_w       = org16 ? sh_next[DATA_W-1:0] : {{HALF{1'b0}}, sh_next[HALF-1:0]};
    needs_data_w = (op_w == OP_WRITE) || ((op_w == OP_EXT) && (sub_w == SUB_FILL));
    can_go       = wren & ~eng_busy & ~go;
    last_idx     = org16 ? IW'(DATA_W - 1) : IW'(HALF - 1);
    hi_idx       = IW'(DATA_W - 1) - ridx;
    lo_idx       = IW'(HALF - 1) - ridx;
    rd_bit       = (org16 || !ptr[0]) ? rd_word[hi_idx] : rd_word[lo_idx];
    ptr_inc      = org16 ? {1'b0, ptr[WORD_AW-1:0] + 1'b1} : ptr + 1'b1;
    rd_addr      = org16 ? ptr[WORD_AW-1:0] : ptr[BYTE_AW-1:1];
    stat         = (st == FE_STAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FE_IDLE; cnt <= '0; shreg <= '0; op_r <= '0; addr_r <= '0;
      ptr <= '0; ridx <= '0; rdbit <= 1'b0; go <= 1'b0; kind <= PK_ERASE1;
      p_addr <= '0; p_data <= '0; wren <= 1'b0; so <= 1'b0; so_en <= 1'b0;
    end else begin
      go    <= 1'b0;
      so_en <= s_cs && ((st == FE_READ) || (st == FE_STAT));
      so    <= (st == FE_READ) ? rdbit : ~(eng_busy | go);
      if (!s_cs) begin
        st  <= FE_IDLE;
        cnt <= '0;
      end else if (rise) begin
        case (st)
          FE_IDLE, FE_STAT: if (s_di) begin
            st <= FE_SHIFT; cnt <= '0; shreg <= '0;
          end
          FE_SHIFT: begin
            shreg <= sh_next[KW-2:0];
            cnt   <= cnt_next;
            if (cnt_next == n_addr) begin
              op_r   <= op_w;
              addr_r <= addr_w;
              if (op_w == OP_READ) begin
                st <= FE_READ; ptr <= addr_w; ridx <= '0; rdbit <= 1'b0;
              end else if (!needs_data_w) begin
                st <= FE_IDLE;
                if ((op_w == OP_EXT) && (sub_w == SUB_ARM)) wren <= 1'b1;
                else if ((op_w == OP_EXT) && (sub_w == SUB_LOCK)) wren <= 1'b0;
                else if (can_go) begin
                  go     <= 1'b1;
                  kind   <= (op_w == OP_ERASE) ? PK_ERASE1 : PK_ERASEALL;
                  p_addr <= addr_w;
                  p_data <= '0;
                  st     <= FE_STAT;
                end
              end
            end else if (cnt_next == n_data) begin
              st <= FE_IDLE;
              if (can_go) begin
                go     <= 1'b1;
                kind   <= (op_r == OP_WRITE) ? PK_WRITE1 : PK_WRITEALL;
                p_addr <= addr_r;
                p_data <= data_w;
                st     <= FE_STAT;
              end
            end
          end
          FE_READ: begin
            rdbit <= rd_bit;
            if (ridx == last_idx) begin
              ridx <= '0;
              ptr  <= ptr_inc;
            end else begin
              ridx <= ridx + 1'b1;
            end
          end
          default: st <= FE_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_serial_mem.sv
`timescale 1ns/1ps
module mw_serial_mem import mw_pkg::*; #(
  parameter int WORD_AW     = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  input  logic org16,
  output logic so,
  output logic so_en
);
  localparam int HALF = DATA_W / 2;

  logic                eng_busy, prog_go, wr_en_flag, fe_stat;
  prog_kind_e          prog_kind;
  logic [WORD_AW:0]    prog_addr;
  logic [DATA_W-1:0]   prog_data, rd_word;
  logic [WORD_AW-1:0]  rd_addr, bank_addr;
  logic [1:0]          bank_we;
  logic [HALF-1:0]     bank_hi, bank_lo;

  mw_frontend #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_fe (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .org16(org16),
    .eng_busy(eng_busy), .rd_word(rd_word), .rd_addr(rd_addr),
    .go(prog_go), .kind(prog_kind), .p_addr(prog_addr), .p_data(prog_data),
    .wren(wr_en_flag), .stat(fe_stat), .so(so), .so_en(so_en)
  );

  mw_prog_engine #(.WORD_AW(WORD_AW), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .go(prog_go), .kind(prog_kind), .p_addr(prog_addr),
    .p_data(prog_data), .org16(org16), .busy(eng_busy), .we(bank_we),
    .w_addr(bank_addr), .w_hi(bank_hi), .w_lo(bank_lo)
  );

  mw_store #(.WORD_AW(WORD_AW), .HALF(HALF)) u_store (
    .clk(clk), .we(bank_we), .w_addr(bank_addr), .w_hi(bank_hi), .w_lo(bank_lo),
    .r_addr(rd_addr), .r_word(rd_word)
  );
endmodule

// File: rtl/mw_serial_mem_chk.sv
`timescale 1ns/1ps
module mw_serial_mem_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       so,
  input logic       so_en,
  input logic       eng_busy,
  input logic       prog_go,
  input logic       fe_stat,
  input logic       wr_en_flag,
  input logic [1:0] bank_we
);
  // R8: two low chip-select samples force the output enable off
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (!cs ##1 !cs) |=> !so_en);

  // R8: the output is only enabled when chip select was high two clocks earlier
  a_r8_en_needs_cs: assert property (@(posedge clk) disable iff (rst)
    so_en |-> $past(cs, 2));

  // R9: status display shows busy as a 0
  a_r9_busy_low: assert property (@(posedge clk) disable iff (rst)
    (so_en && $past(fe_stat) && $past(eng_busy)) |-> !so);

  // R9: the engine only starts after a launch pulse from the decoder
  a_r9_busy_follows_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(prog_go));

  // R6: storage is written only inside a programming cycle
  a_r6_we_only_busy: assert property (@(posedge clk) disable iff (rst)
    (bank_we != 2'b00) |-> eng_busy);

  // R6: a launch is never issued while programming is disabled
  a_r6_launch_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(wr_en_flag, 2));
endmodule

bind mw_serial_mem mw_serial_mem_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .so(so), .so_en(so_en),
  .eng_busy(eng_busy), .prog_go(prog_go), .fe_stat(fe_stat),
  .wr_en_flag(wr_en_flag), .bank_we(bank_we)
);

// File: tb/sim_mw_serial_mem.sv
`timescale 1ns/1ps
module sim_mw_serial_mem;
  localparam int WORD_AW     = 10;
  localparam int DATA_W      = 16;
  localparam int PROG_CYCLES = 40;
  localparam int HP          = 4;
  localparam int NWORD       = 1 << WORD_AW;
  localparam int NBYTE       = 2 * NWORD;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, di = 1'b0, org16 = 1'b1;
  logic so, so_en;
  logic s_so = 1'b0, s_en = 1'b0;
  logic wr_ok = 1'b0;
  logic [7:0] mb [NBYTE];
  int n_tests = 0, n_fail = 0, lowcnt = 0;

  always #4 clk = ~clk;

  mw_serial_mem #(.WORD_AW(WORD_AW), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .org16(org16),
    .so(so), .so_en(so_en)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R8 per-clock monitor: released from the third low clock of chip select on
  always @(negedge clk) begin
    if (cs) lowcnt = 0; else lowcnt++;
    if (!rst && lowcnt >= 3) check("R8 released while deselected", so_en, 1'b0);
  end

  function automatic int aw();
    return org16 ? WORD_AW : WORD_AW + 1;
  endfunction

  function automatic logic [15:0] mword(input int a);
    return org16 ? {mb[2*a], mb[2*a+1]} : {8'h00, mb[a]};
  endfunction

  task automatic tick(input logic b);
    @(negedge clk); di = b; sclk = 1'b1;
    repeat (HP) @(negedge clk);
    sclk = 1'b0;
    repeat (HP) @(negedge clk);
    s_so = so; s_en = so_en;
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic open_sel();
    @(negedge clk); cs = 1'b1; di = 1'b0; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_sel();
    @(negedge clk); cs = 1'b0; di = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 release after deselect", so_en, 1'b0);
  endtask

  task automatic do_read(input int a, input int nw, input int idle, input string tag);
    int p = a;
    open_sel();
    for (int i = 0; i < idle; i++) begin
      tick(1'b0);
      check("R1 idle before start", s_en, 1'b0);
    end
    tick(1'b1); send(2, 2'b10); send(aw(), a);
    check("R4 dummy enable", s_en, 1'b1);
    check("R4 dummy zero", s_so, 1'b0);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] got = '0;
      for (int b = 0; b < (org16 ? 16 : 8); b++) begin
        tick(1'b0);
        got = {got[14:0], s_so};
      end
      check(tag, got, mword(p));
      p = (p + 1) % (org16 ? NWORD : NBYTE);
    end
    close_sel();
  endtask

  task automatic do_prog(input logic [1:0] op, input int a, input logic [15:0] d, input string tag);
    logic [1:0] sub = org16 ? a[9:8] : a[10:9];
    logic hasdata = (op == 2'b01) || (op == 2'b00 && sub == 2'b01);
    logic launch = wr_ok && (op == 2'b11 || op == 2'b01 || (op == 2'b00 && (sub == 2'b10 || sub == 2'b01)));
    open_sel();
    tick(1'b1); send(2, op); send(aw(), a);
    if (hasdata) send(org16 ? 16 : 8, d);
    check({tag, " R9 status enable"}, s_en, launch);
    if (launch) begin
      check({tag, " R9 busy"}, s_so, 1'b0);
      repeat (PROG_CYCLES + NWORD + 40) @(negedge clk);
      tick(1'b0);
      check({tag, " R9 ready enable"}, s_en, 1'b1);
      check({tag, " R9 ready"}, s_so, 1'b1);
      tick(1'b1);
      check({tag, " R9 ends at start bit"}, s_en, 1'b0);
    end
    close_sel();
    if (op == 2'b00 && sub == 2'b11) wr_ok = 1'b1;
    if (op == 2'b00 && sub == 2'b00) wr_ok = 1'b0;
    if (launch) begin
      if (op == 2'b11) begin
        if (org16) begin mb[2*a] = 8'hFF; mb[2*a+1] = 8'hFF; end else mb[a] = 8'hFF;
      end else if (op == 2'b01) begin
        if (org16) begin mb[2*a] = d[15:8]; mb[2*a+1] = d[7:0]; end else mb[a] = d[7:0];
      end else if (sub == 2'b10) begin
        for (int i = 0; i < NBYTE; i++) mb[i] = 8'hFF;
      end else begin
        for (int i = 0; i < NBYTE; i++) mb[i] = org16 ? ((i % 2 == 0) ? d[15:8] : d[7:0]) : d[7:0];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTE; i++) mb[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset state released", so_en, 1'b0);

    org16 = 1'b1;
    do_prog(2'b00, 'h200, 16'h0, "R6 erase-all while disabled");
    do_prog(2'b00, 'h300, 16'h0, "R2 enable");
    do_prog(2'b00, 'h200, 16'h0, "R10 erase-all");
    do_read(5, 1, 5, "R10 R1 read after erase-all");
    do_prog(2'b00, 'h000, 16'h0, "R2 disable");
    do_prog(2'b01, 3, 16'hA55A, "R6 write while disabled");
    do_read(3, 1, 0, "R6 word unchanged");
    do_prog(2'b00, 'h3FF, 16'h0, "R2 enable with ignored bits");
    do_prog(2'b01, 3, 16'hA55A, "R11 write word");
    do_read(3, 1, 2, "R11 R4 read word");

    org16 = 1'b0;
    do_prog(2'b01, 7, 16'h003C, "R11 write byte");
    do_read(6, 2, 0, "R3 R5 byte sequence");
    org16 = 1'b1;
    do_read(3, 1, 0, "R3 byte placement in word");

    do_prog(2'b01, NWORD - 1, 16'h0BEE, "R11 write top word");
    do_read(NWORD - 1, 2, 0, "R5 wrap to zero");
    do_read(2, 3, 0, "R5 sequential words");

    open_sel();
    tick(1'b1); send(2, 2'b01); send(aw(), 0); send(5, 5'h11);
    close_sel();
    do_read(0, 1, 0, "R7 R12 incomplete write ignored");

    do_prog(2'b11, 3, 16'h0, "R10 erase word");
    do_read(3, 1, 0, "R10 erased word");

    do_prog(2'b00, 'h100, 16'h1234, "R11 write-all words");
    do_read(700, 1, 0, "R11 write-all readback");
    org16 = 1'b0;
    do_prog(2'b00, 'h200, 16'h005A, "R11 write-all bytes");
    org16 = 1'b1;
    do_read(4, 1, 0, "R11 R3 byte fill in both halves");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule